// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even parity bit of a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable field. When the local agent drives a phase, it computes parity over the 36 bus bits and presents it on the following clock. The output enable for the parity pin is high only for that clock.

When another agent drives a phase, the block captures the parity of the received bus bits. One clock later it compares that parity with the incoming parity pin. A data-phase mismatch is reported on the active-low data-error output two clocks after the bad data. An address-phase mismatch goes to the active-low system-error output instead. Two enable inputs gate the reporting. Sticky status bits record every error whatever the enables, and writing a one clears them.

The pipeline takes a new phase on every clock, so back-to-back phases each get their own parity and error timing. Pad and tristate electrical behaviour, arbitration and the transaction state machine belong to other blocks.

Top module: `pci_parity_unit`

## Requirements
- R1: When `par_oe` is high, `par_out` equals the XOR of the 32 `ad_in` bits and the 4 `cbe_in` bits sampled in the previous clock, so the 37 bits together hold an even number of ones.
- R2: `par_oe` is high in exactly those clocks that follow a clock with `local_drive` high and `addr_phase` or `data_phase` high.
- R3: A received phase is one with `addr_phase` or `data_phase` high and `local_drive` low. If both phase flags are high, the phase is an address phase. Its error condition is a mismatch between the parity of its bus bits and `par_in` in the next clock.
- R4: For a received data phase in clock T where `perr_resp_en` is high in clock T+1, `perr_oe` is high in clock T+2. In that clock `perr_n` is low if the phase had an error and high otherwise.
- R5: For a received address phase in clock T with an error, where `serr_en` is high in clock T+1, both `serr_oe` and `serr_n`=0 apply in clock T+2. Address errors never drive `perr_n` low.
- R6: When `perr_resp_en` is low in clock T+1, `perr_oe` is low in clock T+2. When `serr_en` is low in clock T+1, `serr_oe` is low in clock T+2. When no error is reported, `perr_n` and `serr_n` are high.
- R7: `sts_data_err` and `sts_addr_err` are set in clock T+2 by a data or address error of phase T, whatever the enables. They stay set until a clock in which `clr_status[0]` (data) or `clr_status[1]` (address) is high. A new error in the same clock as a clear wins.
- R8: Phases on consecutive clocks are each generated and checked independently.
- R9: After reset, `par_out`=0, `par_oe`=0, `perr_oe`=0, `perr_n`=1, `serr_oe`=0, `serr_n`=1 and both status bits are 0.
- R10: Locally driven phases are never checked, so `par_in` has no effect after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data bus value of the current clock |
| cbe_in | input | 4 | Command/byte-enable value of the current clock |
| par_in | input | 1 | Parity pin as seen on the bus |
| addr_phase | input | 1 | Current clock is an address phase |
| data_phase | input | 1 | Current clock is a data phase |
| local_drive | input | 1 | Local agent drives the bus in this phase |
| perr_resp_en | input | 1 | Enables data parity error reporting |
| serr_en | input | 1 | Enables system error reporting |
| clr_status | input | 2 | Write-one-to-clear for status: bit 0 data, bit 1 address |
| par_out | output | 1 | Generated parity |
| par_oe | output | 1 | Output enable for generated parity |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Output enable for perr_n |
| serr_n | output | 1 | System error, active low |
| serr_oe | output | 1 | Output enable for serr_n |
| sts_data_err | output | 1 | Sticky data parity error status |
| sts_addr_err | output | 1 | Sticky address parity error status |

## Verification
The properties assume the phase flags, drive flag and enables are stable, known values at each rising edge. They also assume `par_in` in the clock after a received phase belongs to that phase. The properties make no assumption about how phases are spaced. The stimulus changes every input only on the falling edge. It steps through all combinations of phase flags, drive direction, enables, correct or corrupted parity and clears, with random and extreme bus values, so every pattern of consecutive phases appears.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Address flag takes priority when both flags are raised together.
  function automatic phase_e decode_phase(input logic is_addr, input logic is_data);
    if (is_addr)      return PH_ADDR;
    else if (is_data) return PH_DATA;
    else              return PH_IDLE;
  endfunction

endpackage

// File: rtl/par_calc.sv
module par_calc #(
  parameter int W = 36
) (
  input  logic [W-1:0] bus,
  output logic         par
);

  // Even parity: the bit that makes the total count of ones even.
  function automatic logic even_parity(input logic [W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

  assign par = even_parity(bus);

endmodule

// File: rtl/par_tx_stage.sv
module par_tx_stage
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   local_drive,
  input  logic   bus_par,
  output logic   par_out,
  output logic   par_oe,
  output logic   tx_evt
);

  assign tx_evt = (phase != PH_IDLE) && local_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_oe <= tx_evt;
      if (tx_evt) par_out <= bus_par;
    end
  end

endmodule

// File: rtl/par_rx_stage.sv
module par_rx_stage
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   local_drive,
  input  logic   bus_par,
  input  logic   par_in,
  output logic   chk_data_evt,
  output logic   data_err_evt,
  output logic   addr_err_evt
);

  phase_e held_kind;
  logic   held_par;
  logic   mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_kind <= PH_IDLE;
      held_par  <= 1'b0;
    end else begin
      held_kind <= local_drive ? PH_IDLE : phase;
      held_par  <= bus_par;
    end
  end

  assign mismatch     = held_par ^ par_in;
  assign chk_data_evt = (held_kind == PH_DATA);
  assign data_err_evt = chk_data_evt && mismatch;
  assign addr_err_evt = (held_kind == PH_ADDR) && mismatch;

endmodule

// File: rtl/par_report.sv
module par_report (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_data_evt,
  input  logic       data_err_evt,
  input  logic       addr_err_evt,
  input  logic       perr_resp_en,
  input  logic       serr_en,
  input  logic [1:0] clr_status,
  output logic       perr_n,
  output logic       perr_oe,
  output logic       serr_n,
  output logic       serr_oe,
  output logic       sts_data_err,
  output logic       sts_addr_err
);

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_n       <= 1'b1;
      perr_oe      <= 1'b0;
      serr_n       <= 1'b1;
      serr_oe      <= 1'b0;
      sts_data_err <= 1'b0;
      sts_addr_err <= 1'b0;
    end else begin
      perr_oe      <= chk_data_evt && perr_resp_en;
      perr_n       <= !(data_err_evt && perr_resp_en);
      serr_oe      <= addr_err_evt && serr_en;
      serr_n       <= !(addr_err_evt && serr_en);
      sts_data_err <= sticky_next(sts_data_err, data_err_evt, clr_status[0]);
      sts_addr_err <= sticky_next(sts_addr_err, addr_err_evt, clr_status[1]);
    end
  end

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             data_phase,
  input  logic             local_drive,
  input  logic             perr_resp_en,
  input  logic             serr_en,
  input  logic [1:0]       clr_status,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_n,
  output logic             perr_oe,
  output logic             serr_n,
  output logic             serr_oe,
  output logic             sts_data_err,
  output logic             sts_addr_err
);

  localparam int BUS_W = AD_W + CBE_W;

  phase_e phase;
  logic   bus_par;
  logic   tx_evt;
  logic   chk_data_evt;
  logic   data_err_evt;
  logic   addr_err_evt;

  assign phase = decode_phase(addr_phase, data_phase);

  par_calc #(.W(BUS_W)) u_calc (
    .bus ({cbe_in, ad_in}),
    .par (bus_par)
  );

  par_tx_stage u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .local_drive (local_drive),
    .bus_par     (bus_par),
    .par_out     (par_out),
    .par_oe      (par_oe),
    .tx_evt      (tx_evt)
  );

  par_rx_stage u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .local_drive  (local_drive),
    .bus_par      (bus_par),
    .par_in       (par_in),
    .chk_data_evt (chk_data_evt),
    .data_err_evt (data_err_evt),
    .addr_err_evt (addr_err_evt)
  );

  par_report u_rep (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_data_evt (chk_data_evt),
    .data_err_evt (data_err_evt),
    .addr_err_evt (addr_err_evt),
    .perr_resp_en (perr_resp_en),
    .serr_en      (serr_en),
    .clr_status   (clr_status),
    .perr_n       (perr_n),
    .perr_oe      (perr_oe),
    .serr_n       (serr_n),
    .serr_oe      (serr_oe),
    .sts_data_err (sts_data_err),
    .sts_addr_err (sts_addr_err)
  );

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_in,
  input logic [CBE_W-1:0] cbe_in,
  input logic             addr_phase,
  input logic             data_phase,
  input logic             local_drive,
  input logic             perr_resp_en,
  input logic             serr_en,
  input logic [1:0]       clr_status,
  input logic             par_out,
  input logic             par_oe,
  input logic             perr_n,
  input logic             perr_oe,
  input logic             serr_n,
  input logic             serr_oe,
  input logic             sts_data_err,
  input logic             sts_addr_err,
  input logic             tx_evt,
  input logic             data_err_evt,
  input logic             addr_err_evt
);

  AST_PAR_OE_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_phase || data_phase) && local_drive) |=> par_oe); // R2

  AST_PAR_OE_ONLY_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> $past(tx_evt)); // R2

  AST_PAR_VALUE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ($countones({par_out, $past(ad_in), $past(cbe_in)}) % 2 == 0)); // R1

  AST_DATA_ERR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err_evt && perr_resp_en) |=> (perr_oe && !perr_n)); // R4

  AST_ADDR_ERR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err_evt && serr_en) |=> (serr_oe && !serr_n)); // R5

  AST_ADDR_NOT_ON_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_evt |=> perr_n); // R5

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    perr_oe |-> $past(perr_resp_en)); // R6

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(serr_en)); // R6

  AST_STICKY_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_data_err && !clr_status[0]) |=> sts_data_err); // R7

  AST_STICKY_ADDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_evt |=> sts_addr_err); // R7

endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ad_in        (ad_in),
  .cbe_in       (cbe_in),
  .addr_phase   (addr_phase),
  .data_phase   (data_phase),
  .local_drive  (local_drive),
  .perr_resp_en (perr_resp_en),
  .serr_en      (serr_en),
  .clr_status   (clr_status),
  .par_out      (par_out),
  .par_oe       (par_oe),
  .perr_n       (perr_n),
  .perr_oe      (perr_oe),
  .serr_n       (serr_n),
  .serr_oe      (serr_oe),
  .sts_data_err (sts_data_err),
  .sts_addr_err (sts_addr_err),
  .tx_evt       (tx_evt),
  .data_err_evt (data_err_evt),
  .addr_err_evt (addr_err_evt)
);

// File: tb/test_pci_parity_unit.sv
module test_pci_parity_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 3072;
  localparam int HOFF       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic        par_in = 1'b0;
  logic        addr_phase = 1'b0, data_phase = 1'b0, local_drive = 1'b0;
  logic        perr_resp_en = 1'b0, serr_en = 1'b0;
  logic [1:0]  clr_status = '0;
  logic        par_out, par_oe, perr_n, perr_oe, serr_n, serr_oe;
  logic        sts_data_err, sts_addr_err;

  int checks = 0;
  int fails  = 0;

  // per-cycle stimulus history, index = cycle + HOFF
  logic [1:0] h_kind  [NCYC+HOFF];
  logic       h_local [NCYC+HOFF];
  logic       h_par   [NCYC+HOFF];
  logic       h_pin   [NCYC+HOFF];
  logic       h_pe    [NCYC+HOFF];
  logic       h_se    [NCYC+HOFF];
  logic [1:0] h_clr   [NCYC+HOFF];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_parity_unit i_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .addr_phase(addr_phase), .data_phase(data_phase), .local_drive(local_drive),
    .perr_resp_en(perr_resp_en), .serr_en(serr_en), .clr_status(clr_status),
    .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n), .perr_oe(perr_oe),
    .serr_n(serr_n), .serr_oe(serr_oe),
    .sts_data_err(sts_data_err), .sts_addr_err(sts_addr_err)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Bench parity: count ones, result 1 when the count is odd.
  function automatic logic ones_odd(input logic [35:0] v);
    int n = 0;
    for (int i = 0; i < 36; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  logic model_sd = 1'b0;
  logic model_sa = 1'b0;
  bit   done = 1'b0;

  initial begin
    for (int i = 0; i < NCYC + HOFF; i++) begin
      h_kind[i] = 2'd0; h_local[i] = 1'b0; h_par[i] = 1'b0; h_pin[i] = 1'b0;
      h_pe[i] = 1'b0; h_se[i] = 1'b0; h_clr[i] = 2'd0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "par_out",  par_out, 1'b0);
    check("R9", "par_oe",   par_oe, 1'b0);
    check("R9", "perr_oe",  perr_oe, 1'b0);
    check("R9", "perr_n",   perr_n, 1'b1);
    check("R9", "serr_oe",  serr_oe, 1'b0);
    check("R9", "serr_n",   serr_n, 1'b1);
    check("R9", "sts_data", sts_data_err, 1'b0);
    check("R9", "sts_addr", sts_addr_err, 1'b0);
    rst_n = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      @(negedge clk);
      if (n >= 1) begin
        int i1 = n - 1 + HOFF;
        int i2 = n - 2 + HOFF;
        logic rx2, err2, d_err, a_err, exp_poe;
        // R1, R2: generation for phase n-1
        check("R2", "par_oe", par_oe, (h_kind[i1] != 2'd0) && h_local[i1]);
        if (par_oe === 1'b1) check("R1", "par_out", par_out, h_par[i1]);
        // R3, R10: receive check for phase n-2 with par_in of n-1
        rx2   = (h_kind[i2] != 2'd0) && !h_local[i2];
        err2  = rx2 && (h_par[i2] != h_pin[i1]);
        d_err = err2 && (h_kind[i2] == 2'd2);
        a_err = err2 && (h_kind[i2] == 2'd1);
        exp_poe = rx2 && (h_kind[i2] == 2'd2) && h_pe[i1];
        check("R4", "perr_oe", perr_oe, exp_poe);
        check("R4", "perr_n",  perr_n, !(d_err && h_pe[i1]));
        check("R5", "serr_oe", serr_oe, a_err && h_se[i1]);
        check("R6", "serr_n",  serr_n, !(a_err && h_se[i1]));
        model_sd = d_err | (model_sd & !h_clr[i1][0]);
        model_sa = a_err | (model_sa & !h_clr[i1][1]);
        check("R7", "sts_data_err", sts_data_err, model_sd);
        check("R7", "sts_addr_err", sts_addr_err, model_sa);
      end
      // drive phase n (R8: a new phase may start every clock)
      begin
        int c = n % 256;
        int idx = n + HOFF;
        logic [31:0] ad;
        logic [3:0]  cb;
        ad = $urandom;
        cb = 4'($urandom);
        if (n % 16 == 3)  begin ad = '1; cb = '1; end
        if (n % 16 == 7)  begin ad = '0; cb = '0; end
        if (n % 16 == 11) begin ad = 32'd1 << (n % 32); cb = '0; end
        addr_phase   = c[0];
        data_phase   = c[1];
        local_drive  = c[2];
        perr_resp_en = c[3];
        serr_en      = c[4];
        // par_in in this clock belongs to phase n-1; c[5] corrupts it
        par_in       = h_par[idx-1] ^ c[5];
        clr_status   = {($urandom % 6) == 0, ($urandom % 6) == 0};
        ad_in  = ad;
        cbe_in = cb;
        h_kind[idx]  = c[0] ? 2'd1 : (c[1] ? 2'd2 : 2'd0);
        h_local[idx] = c[2];
        h_par[idx]   = ones_odd({cb, ad});
        h_pin[idx]   = par_in;
        h_pe[idx]    = c[3];
        h_se[idx]    = c[4];
        h_clr[idx]   = clr_status;
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (NCYC + 200) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule